// File: doc/BRIEF.md
# Angle Hold Latch with Byte-Wide Read Port

This block sits between a free-running angle tracking counter and a host bus. A hold register follows the counter on every clock while the counter is quiet and the host has not asked for a freeze. It stops following for the whole of a counter busy pulse, and for one further cycle after it, so that a read never sees a count that is half updated. An active-low inhibit from the host freezes the register for as long as the host keeps it low. The tracking counter keeps running meanwhile, and releasing the inhibit brings the register back up to date on the next clock.

The held angle is presented as two bytes. Each byte has its own active-low enable, its own output-enable flag that stands in for a tri-state driver, and its own valid strobe. The host can read the upper byte and then the lower byte, or it can enable both together for a single 16-bit read. A resolution select picks full-width mode or reduced-width mode, in which the two least significant angle bits always read as zero. The select is taken in only when a busy pulse ends. A settle counter reports when the frozen value may safely be read.

Top module: `angle_latch_bus`

## Requirements
- R1: After reset the hold register is zero, full-width mode is selected, `dataStable`, both valid strobes and both output-enable flags are low, and both data bytes are zero.
- R2: At a clock edge where `busyIn` is low, was also low at the previous edge, and `inhibitN` is high, the hold register loads `countIn`. Bits 15:8 of the register appear on `hiData` and bits 7:0 appear on `loData`.
- R3: At any clock edge where `busyIn` is high, the hold register keeps its value.
- R4: At the first clock edge after `busyIn` falls, the hold register still keeps its value. Loading resumes one edge later.
- R5: While `inhibitN` is low, the hold register keeps its value for any number of cycles. This includes an inhibit that is raised during a busy pulse: the register stays frozen after the pulse ends.
- R6: When `inhibitN` returns high and no busy hold is in force, the register reloads from `countIn` at the next clock edge.
- R7: `hiEnN` low sets `hiOe` and drives the upper byte. `hiEnN` high clears `hiOe` and forces `hiData` to zero. `loEnN` does the same for `loOe` and `loData`. The two enables act independently and may both be low at once.
- R8: `shortMode` (1 = reduced width, 0 = full width) is captured only at the edge that follows the fall of `busyIn`. A change at any other time has no effect on the output. In reduced-width mode, bits 1:0 of `loData` read as zero.
- R9: `dataStable` rises after `inhibitN` has been low for SETTLE_CYC consecutive clock edges (default 4). It falls at the first edge at which `inhibitN` is high.
- R10: A byte's valid strobe is high only when that byte's enable has been low for EN_DLY consecutive edges (default 2) and `dataStable` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| countIn | input | 16 | Live tracking counter value, MSB at bit 15 |
| busyIn | input | 1 | High while the counter is being updated |
| inhibitN | input | 1 | Active-low host freeze request |
| shortMode | input | 1 | 1 selects reduced width, captured at the end of a busy pulse |
| hiEnN | input | 1 | Active-low upper byte enable |
| loEnN | input | 1 | Active-low lower byte enable |
| hiData | output | 8 | Upper byte of the held angle, zero when released |
| hiOe | output | 1 | Upper byte drive flag |
| hiValid | output | 1 | Upper byte may be sampled |
| loData | output | 8 | Lower byte of the held angle, zero when released |
| loOe | output | 1 | Lower byte drive flag |
| loValid | output | 1 | Lower byte may be sampled |
| dataStable | output | 1 | Inhibit has been held long enough for a safe read |

## Verification
The bench goes after the edges where busy and inhibit overlap. One case is an inhibit raised in the middle of a busy pulse. A design that honoured only the inhibit's own edge would reload as soon as the pulse ended. A design that ignored the extra cycle after busy falls would capture the counter during its last update step. A resolution change made outside a busy pulse is applied with all-ones data on the bus. A design that sampled the select directly would clear the low bits at once instead of waiting for the trailing edge. Finally, random stretches that mix enables, inhibit and busy pulses catch a valid strobe raised before settling, or a released byte that still drives data.

// File: rtl/angle_bus_pkg.sv
package angle_bus_pkg;
  typedef struct packed {
    logic loadAngle;   // copy the live count into the hold register
    logic updateMode;  // take in the resolution select
  } latchStrobe_t;
endpackage

// File: rtl/latch_ctrl.sv
module latch_ctrl
  import angle_bus_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busyIn,
  input  logic         inhibitN,
  output latchStrobe_t strobe,
  output logic         dataStable
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SETTLE_MAX = SW'(SETTLE_CYC);

  logic          busyDly;
  logic [SW-1:0] settleCnt;

  // busy is stretched by one register so the final count step never races a load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyDly <= 1'b0;
    else       busyDly <= busyIn;
  end

  always_comb begin
    strobe.loadAngle  = !busyIn && !busyDly && inhibitN;
    strobe.updateMode = busyDly && !busyIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     settleCnt <= '0;
    else if (inhibitN)             settleCnt <= '0;
    else if (settleCnt != SETTLE_MAX) settleCnt <= settleCnt + 1'b1;
  end

  assign dataStable = (settleCnt == SETTLE_MAX);

  AST_SETTLE_ROSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataStable) |-> $past(!inhibitN)); // R9
endmodule

// File: rtl/latch_datapath.sv
module latch_datapath
  import angle_bus_pkg::*;
#(
  parameter int ANGLE_W = 16,
  parameter int SHORT_W = 14
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  latchStrobe_t         strobe,
  input  logic [ANGLE_W-1:0]   countIn,
  input  logic                 shortMode,
  input  logic                 hiOe,
  input  logic                 loOe,
  output logic [ANGLE_W-1:0]   heldAngle,
  output logic [ANGLE_W/2-1:0] hiData,
  output logic [ANGLE_W/2-1:0] loData,
  output logic                 modeShort
);
  localparam int BYTE_W = ANGLE_W / 2;
  localparam int DROP   = ANGLE_W - SHORT_W;

  logic [BYTE_W-1:0] loMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 heldAngle <= '0;
    else if (strobe.loadAngle) heldAngle <= countIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  modeShort <= 1'b0;
    else if (strobe.updateMode) modeShort <= shortMode;
  end

  generate
    if (DROP > 0) begin : g_mask
      assign loMask = modeShort ? {{(BYTE_W-DROP){1'b1}}, {DROP{1'b0}}} : {BYTE_W{1'b1}};
    end else begin : g_nomask
      assign loMask = {BYTE_W{1'b1}};
    end
  endgenerate

  assign hiData = hiOe ? heldAngle[ANGLE_W-1:BYTE_W] : '0;
  assign loData = loOe ? (heldAngle[BYTE_W-1:0] & loMask) : '0;
endmodule

// File: rtl/byte_port.sv
module byte_port #(
  parameter int EN_DLY = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enN,
  input  logic dataStable,
  output logic oe,
  output logic valid
);
  localparam int CW = $clog2(EN_DLY + 1);
  localparam logic [CW-1:0] EN_MAX = CW'(EN_DLY);

  logic [CW-1:0] enCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               enCnt <= '0;
    else if (enN)            enCnt <= '0;
    else if (enCnt != EN_MAX) enCnt <= enCnt + 1'b1;
  end

  assign oe    = !enN;
  assign valid = oe && (enCnt == EN_MAX) && dataStable;

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> $past(!enN)); // R10
endmodule

// File: rtl/angle_latch_bus.sv
module angle_latch_bus
  import angle_bus_pkg::*;
#(
  parameter int ANGLE_W    = 16,
  parameter int SHORT_W    = 14,
  parameter int SETTLE_CYC = 4,
  parameter int EN_DLY     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ANGLE_W-1:0]   countIn,
  input  logic                 busyIn,
  input  logic                 inhibitN,
  input  logic                 shortMode,
  input  logic                 hiEnN,
  input  logic                 loEnN,
  output logic [ANGLE_W/2-1:0] hiData,
  output logic                 hiOe,
  output logic                 hiValid,
  output logic [ANGLE_W/2-1:0] loData,
  output logic                 loOe,
  output logic                 loValid,
  output logic                 dataStable
);
  latchStrobe_t       strobe;
  logic [ANGLE_W-1:0] heldAngle;
  logic               modeShort;
  logic [1:0]         enNVec, oeVec, validVec;

  latch_ctrl #(.SETTLE_CYC(SETTLE_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .inhibitN(inhibitN),
    .strobe(strobe), .dataStable(dataStable)
  );

  latch_datapath #(.ANGLE_W(ANGLE_W), .SHORT_W(SHORT_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .countIn(countIn),
    .shortMode(shortMode), .hiOe(hiOe), .loOe(loOe),
    .heldAngle(heldAngle), .hiData(hiData), .loData(loData),
    .modeShort(modeShort)
  );

  // index 1 = upper byte, index 0 = lower byte
  assign enNVec = {hiEnN, loEnN};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_port
      byte_port #(.EN_DLY(EN_DLY)) uPort (
        .clk(clk), .rstN(rstN), .enN(enNVec[g]), .dataStable(dataStable),
        .oe(oeVec[g]), .valid(validVec[g])
      );
    end
  endgenerate

  assign hiOe    = oeVec[1];
  assign loOe    = oeVec[0];
  assign hiValid = validVec[1];
  assign loValid = validVec[0];

  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |=> $stable(heldAngle)); // R3
  AST_HOLD_INH: assert property (@(posedge clk) disable iff (!rstN)
    !inhibitN |=> $stable(heldAngle)); // R5
  AST_BUSY_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyIn) |=> $stable(heldAngle)); // R4
  AST_MODE_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeShort) |-> $past(!busyIn)); // R8
  AST_HI_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    hiEnN |-> (hiData == '0)); // R7
endmodule

// File: tb/tb_angle_latch_bus.sv
module tb_angle_latch_bus;
  localparam int SETTLE = 4;
  localparam int ENDLY  = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] countIn = '0;
  logic        busyIn = 1'b0, inhibitN = 1'b1, shortMode = 1'b0;
  logic        hiEnN = 1'b1, loEnN = 1'b1;
  logic [7:0]  hiData, loData;
  logic        hiOe, hiValid, loOe, loValid, dataStable;

  int errors = 0, checks = 0;
  bit done = 0;

  // behavioural reference state
  logic [15:0] mHeld = '0;
  bit mMode = 0, mBusyPrev = 0;
  int mSettle = 0, mHiCnt = 0, mLoCnt = 0;

  always #10 clk = ~clk;

  angle_latch_bus dut (
    .clk(clk), .rstN(rstN), .countIn(countIn), .busyIn(busyIn),
    .inhibitN(inhibitN), .shortMode(shortMode), .hiEnN(hiEnN), .loEnN(loEnN),
    .hiData(hiData), .hiOe(hiOe), .hiValid(hiValid),
    .loData(loData), .loOe(loOe), .loValid(loValid), .dataStable(dataStable)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // full comparison of every output against the reference model
  task automatic compareAll();
    logic [7:0] eHi, eLo;
    bit eStable;
    eStable = (mSettle == SETTLE);
    eHi = !hiEnN ? mHeld[15:8] : 8'h00;
    eLo = !loEnN ? (mHeld[7:0] & (mMode ? 8'hFC : 8'hFF)) : 8'h00;
    chk(hiData == eHi, "R2/R7 hiData", hiData, eHi);
    chk(loData == eLo, "R2/R8 loData", loData, eLo);
    chk(hiOe == !hiEnN && loOe == !loEnN, "R7 oe", {hiOe, loOe}, {!hiEnN, !loEnN});
    chk(dataStable == eStable, "R9 dataStable", dataStable, eStable);
    chk(hiValid == (!hiEnN && mHiCnt == ENDLY && eStable), "R10 hiValid", hiValid,
        (!hiEnN && mHiCnt == ENDLY && eStable));
    chk(loValid == (!loEnN && mLoCnt == ENDLY && eStable), "R10 loValid", loValid,
        (!loEnN && mLoCnt == ENDLY && eStable));
  endtask

  task automatic step();
    bit ld, mu;
    @(posedge clk);
    ld = !busyIn && !mBusyPrev && inhibitN;
    mu = mBusyPrev && !busyIn;
    if (ld) mHeld = countIn;
    if (mu) mMode = shortMode;
    mSettle = inhibitN ? 0 : (mSettle < SETTLE ? mSettle + 1 : SETTLE);
    mHiCnt  = hiEnN ? 0 : (mHiCnt < ENDLY ? mHiCnt + 1 : ENDLY);
    mLoCnt  = loEnN ? 0 : (mLoCnt < ENDLY ? mLoCnt + 1 : ENDLY);
    mBusyPrev = busyIn;
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(20 * 50000);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(hiData == 0 && loData == 0 && !hiOe && !loOe, "R1 bus idle", {hiData, loData}, 0);
    chk(!dataStable && !hiValid && !loValid, "R1 flags", {dataStable, hiValid, loValid}, 0);
    rstN = 1'b1;
    hiEnN = 0; loEnN = 0;
    @(negedge clk);
    chk({hiData, loData} == 16'h0000, "R1 held zero", {hiData, loData}, 0);

    // R2: transparent following
    countIn = 16'hA5C3; step();
    chk({hiData, loData} == 16'hA5C3, "R2 follow", {hiData, loData}, 16'hA5C3);
    countIn = 16'h0F0F; step();
    chk({hiData, loData} == 16'h0F0F, "R2 follow2", {hiData, loData}, 16'h0F0F);

    // R3 and R4: busy hold plus one-cycle tail
    busyIn = 1; step();
    countIn = 16'h1234; step(); step();
    chk({hiData, loData} == 16'h0F0F, "R3 busy hold", {hiData, loData}, 16'h0F0F);
    busyIn = 0; step();
    chk({hiData, loData} == 16'h0F0F, "R4 tail hold", {hiData, loData}, 16'h0F0F);
    step();
    chk({hiData, loData} == 16'h1234, "R4 resume", {hiData, loData}, 16'h1234);

    // R5 and R9: inhibit hold for a long time, settle flag
    inhibitN = 0;
    for (int i = 0; i < 20; i++) begin
      countIn = 16'(i * 16'h0777); step();
      if (i == SETTLE - 2) chk(!dataStable, "R9 not yet", dataStable, 0);
      if (i == SETTLE - 1) chk(dataStable, "R9 settled", dataStable, 1);
    end
    chk({hiData, loData} == 16'h1234, "R5 inhibit hold", {hiData, loData}, 16'h1234);
    chk(hiValid && loValid, "R10 both valid", {hiValid, loValid}, 2'b11);

    // R6: release reloads on next edge
    countIn = 16'hBEEF; inhibitN = 1; step();
    chk({hiData, loData} == 16'hBEEF, "R6 reload", {hiData, loData}, 16'hBEEF);
    chk(!dataStable, "R9 drop", dataStable, 0);

    // R5: inhibit raised during busy persists past the pulse
    busyIn = 1; step();
    inhibitN = 0; countIn = 16'h5555; step();
    busyIn = 0; step(); step(); step();
    chk({hiData, loData} == 16'hBEEF, "R5 inh in busy", {hiData, loData}, 16'hBEEF);
    inhibitN = 1; step();
    chk({hiData, loData} == 16'h5555, "R6 after busy", {hiData, loData}, 16'h5555);

    // R8: select ignored outside busy trailing edge
    countIn = 16'hFFFF; shortMode = 1; step(); step();
    chk(loData == 8'hFF, "R8 ignored", loData, 8'hFF);
    busyIn = 1; step(); busyIn = 0; step(); step();
    chk(loData == 8'hFC, "R8 short", loData, 8'hFC);
    shortMode = 0; step();
    chk(loData == 8'hFC, "R8 held", loData, 8'hFC);

    // R7: independent enables
    hiEnN = 1; step();
    chk(hiData == 0 && !hiOe && loOe, "R7 hi released", {hiData, hiOe, loOe}, 1);
    loEnN = 1; hiEnN = 0; step();
    chk(hiData == 8'hFF && loData == 0 && !loOe, "R7 lo released", {hiData, loData}, 16'hFF00);

    // R10: enables only just low give no valid
    inhibitN = 0; hiEnN = 1; repeat (SETTLE + 1) step();
    hiEnN = 0; step();
    chk(!hiValid, "R10 early", hiValid, 0);
    step();
    chk(hiValid, "R10 late", hiValid, 1);

    // random mixture compared every cycle
    for (int i = 0; i < 600; i++) begin
      countIn   = 16'($urandom);
      if (($urandom % 7) == 0) busyIn = ~busyIn;
      if (($urandom % 11) == 0) inhibitN = ~inhibitN;
      if (($urandom % 5) == 0) hiEnN = ~hiEnN;
      if (($urandom % 5) == 0) loEnN = ~loEnN;
      if (($urandom % 13) == 0) shortMode = ~shortMode;
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule